// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block sits between an interrupt distributor and one processor core. Every cycle the distributor offers its best candidate: an interrupt number and an 8-bit priority, where a smaller value means more urgent. The block decides whether that candidate may disturb the core. It checks an enable bit, a programmable priority threshold and the priority of the work the core is already running. When the candidate passes, the block raises the request line to the core.

Software talks to the block through a 32-bit register port with word addresses. A read of the claim register returns the candidate's number and makes that interrupt active. In the same cycle it sends a one-cycle strobe back to the distributor. If nothing passes, the read returns the reserved number 1023 and changes nothing. Software closes an interrupt by writing its number to the completion register. A matching write retires the innermost active interrupt and sends a one-cycle completion strobe. A write that does not match is ignored.

Active interrupts are held in a small stack of running priorities. Its depth is a parameter, and the default of 2 allows one level of preemption.

Top module: `cpu_int_iface`

## Requirements
- R1: After reset the control bit and the threshold are 0, the request line is low, and a claim read returns 1023.
- R2: A claim read (word address 2) while the candidate qualifies returns the candidate number in bits [9:0] with zeros above. In the same cycle it pulses `ack_stb` with `ack_id` equal to that number. From the next cycle the interrupt is the innermost active one.
- R3: A claim read while nothing qualifies returns 1023, gives no `ack_stb`, and leaves the active stack unchanged.
- R4: The threshold register (word address 1, bits [7:0]) lets a candidate through only if its priority value is strictly below the threshold. With 0xF0, priority 0xEF passes and 0xF0 is blocked.
- R5: Control bit 0 (word address 0) enables signalling. While it is 0, `irq_o` stays low and claim reads return 1023.
- R6: A candidate numbered 1021, 1022 or 1023 never qualifies, whatever its priority.
- R7: While an interrupt is active, a candidate qualifies only if its priority value is strictly below the innermost active priority. An equal value does not qualify.
- R8: A write to word address 3 whose bits [9:0] equal the innermost active number retires that interrupt. In the same cycle it pulses `eoi_stb` with `eoi_id` equal to that number. A write with any other number, or a write when nothing is active, is ignored.
- R9: When DEPTH interrupts are active, no candidate qualifies until one is retired.
- R10: `irq_o` is high exactly when the candidate qualifies: enabled, `cand_valid` high, number not reserved, below the threshold, below the running priority, and stack not full.
- R11: The control and threshold registers read back as written, in bit 0 and bits [7:0]. Reads of any other word address return 0, and writes to other word addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | Distributor has a candidate |
| cand_id | input | 10 | Candidate interrupt number |
| cand_prio | input | 8 | Candidate priority, smaller is more urgent |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the core |
| ack_stb | output | 1 | Claim strobe to the distributor |
| ack_id | output | 10 | Number being claimed |
| eoi_stb | output | 1 | Completion strobe to the distributor |
| eoi_id | output | 10 | Number being retired |

## Verification
Two things can collide in one cycle: the distributor changes its candidate, and software reads the claim register. The claim must return the candidate of that very cycle, and the running priority it pushes must be that candidate's priority. The bench provokes this by switching the candidate in the same cycle as the claim read. A reference model, built from queues and compared on every clock, judges the result, including the request line in the cycles that follow. A random phase also places completions right after claims, so that the request line must come back in the cycle after the matching completion.

// File: rtl/cii_pkg.sv
// Package: shared widths, reserved interrupt numbers and the register word map
// of the per-CPU interrupt interface.
package cii_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0] SPURIOUS_ID    = 10'd1023;
    localparam logic [ID_W-1:0] FIRST_RESERVED = 10'd1021;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_MASK  = 2'd1,
        REG_CLAIM = 2'd2,
        REG_DONE  = 2'd3
    } reg_word_e;
endpackage

// File: rtl/cii_regs.sv
// Module: cii_regs
// Decodes the register port and holds the enable bit and the priority threshold.
// It also flags claim reads and completion writes.
// Assumes that one access arrives per cycle and that reads have no wait state.
module cii_regs
    import cii_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ctrl_en,
    output logic [PRIO_W-1:0] mask_q,
    output logic              claim_rd,
    output logic              done_wr,
    output logic [DATA_W-1:0] cfg_rdata
);
    logic hit_ctrl, hit_mask;

    // Word address decode.
    always_comb begin
        hit_ctrl = bus_sel && (bus_addr == ADDR_W'(REG_CTRL));
        hit_mask = bus_sel && (bus_addr == ADDR_W'(REG_MASK));
        claim_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(REG_CLAIM));
        done_wr  = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(REG_DONE));
    end

    // Enable bit and threshold storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            if (hit_ctrl) ctrl_en <= bus_wdata[0];
            if (hit_mask) mask_q  <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Readback of the configuration words.
    always_comb begin
        cfg_rdata = '0;
        if (!bus_wr) begin
            if (hit_ctrl) cfg_rdata[0]          = ctrl_en;
            if (hit_mask) cfg_rdata[PRIO_W-1:0] = mask_q;
        end
    end
endmodule

// File: rtl/cii_qualify.sv
// Module: cii_qualify
// Decides whether the distributor's candidate may signal the core or be claimed.
// Assumes that a smaller priority value means more urgent and that the
// running priority is meaningful only while the stack is not empty.
module cii_qualify
    import cii_pkg::*;
(
    input  logic              en,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] mask_q,
    input  logic              stk_empty,
    input  logic              stk_full,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              qualifies
);
    logic id_ok, below_mask, below_run;

    // Each condition on its own, then all of them combined.
    always_comb begin
        id_ok      = cand_id < FIRST_RESERVED;
        below_mask = cand_prio < mask_q;
        below_run  = stk_empty || (cand_prio < run_prio);
        qualifies  = en && cand_valid && id_ok && below_mask && below_run && !stk_full;
    end
endmodule

// File: rtl/cii_prio_stack.sv
// Module: cii_prio_stack
// LIFO of active interrupts: each entry holds a number and its priority.
// The top entry gives the running priority.
// Assumes that push and pop never come together and that the caller
// never pushes when full or pops when empty.
module cii_prio_stack
    import cii_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [ID_W-1:0]   top_id,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  depth
);
    logic [DEPTH-1:0][ID_W-1:0]   ids;
    logic [DEPTH-1:0][PRIO_W-1:0] prios;

    // Fill level.
    always_ff @(posedge clk) begin
        if (!rst_n)    depth <= '0;
        else if (push) depth <= depth + 1'b1;
        else if (pop)  depth <= depth - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ID_W-1:0]   s_id;
        logic [PRIO_W-1:0] s_prio;
        // Slot g loads when a push lands on it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_id   <= '0;
                s_prio <= '0;
            end else if (push && depth == CNT_W'(g)) begin
                s_id   <= push_id;
                s_prio <= push_prio;
            end
        end
        assign ids[g]   = s_id;
        assign prios[g] = s_prio;
    end

    // Select the innermost entry.
    always_comb begin
        top_id   = '0;
        top_prio = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth == CNT_W'(i + 1)) begin
                top_id   = ids[i];
                top_prio = prios[i];
            end
        end
        empty = depth == '0;
        full  = depth == CNT_W'(DEPTH);
    end
endmodule

// File: rtl/cpu_int_iface.sv
// Module: cpu_int_iface (top)
// Per-CPU interrupt interface. It gates the distributor's candidate into the
// request line and serves claim reads and completion writes, each with a
// one-cycle strobe in the access cycle.
// Assumes that the candidate inputs are stable within a cycle.
module cpu_int_iface
    import cii_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [9:0]        cand_id,
    input  logic [7:0]        cand_prio,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              ack_stb,
    output logic [9:0]        ack_id,
    output logic              eoi_stb,
    output logic [9:0]        eoi_id
);
    logic              ctrl_en, claim_rd, done_wr, qualifies;
    logic [PRIO_W-1:0] mask_q, run_prio;
    logic [DATA_W-1:0] cfg_rdata;
    logic [ID_W-1:0]   top_id;
    logic              stk_empty, stk_full;
    logic [CNT_W-1:0]  stk_depth;

    cii_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_en(ctrl_en),
        .mask_q(mask_q), .claim_rd(claim_rd), .done_wr(done_wr),
        .cfg_rdata(cfg_rdata)
    );

    cii_qualify u_qual (
        .en(ctrl_en), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_prio(cand_prio), .mask_q(mask_q), .stk_empty(stk_empty),
        .stk_full(stk_full), .run_prio(run_prio), .qualifies(qualifies)
    );

    cii_prio_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(ack_stb), .push_id(cand_id),
        .push_prio(cand_prio), .pop(eoi_stb), .top_id(top_id),
        .top_prio(run_prio), .empty(stk_empty), .full(stk_full),
        .depth(stk_depth)
    );

    // Claim and completion strobes, request line and read data mux.
    always_comb begin
        irq_o     = qualifies;
        ack_stb   = claim_rd && qualifies;
        ack_id    = cand_id;
        eoi_stb   = done_wr && !stk_empty && (bus_wdata[ID_W-1:0] == top_id);
        eoi_id    = top_id;
        bus_rdata = cfg_rdata;
        if (claim_rd)
            bus_rdata = {{(DATA_W-ID_W){1'b0}}, (qualifies ? cand_id : SPURIOUS_ID)};
    end
endmodule

// File: rtl/cpu_int_iface_chk.sv
// Module: cpu_int_iface_chk
// Assertion checker attached to cpu_int_iface via bind.
module cpu_int_iface_chk #(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              ack_stb,
    input logic [9:0]        ack_id,
    input logic              eoi_stb,
    input logic [7:0]        cand_prio,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              ctrl_en,
    input logic [7:0]        mask_q,
    input logic [CNT_W-1:0]  stk_depth
);
    logic claim_read;
    assign claim_read = bus_sel && !bus_wr && (bus_addr == ADDR_W'(2));

    p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !irq_o);
    p_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_read && !ack_stb) |-> bus_rdata == 32'd1023);
    p_claim_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> stk_depth == $past(stk_depth) + 1'b1);
    p_retire_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |=> stk_depth == $past(stk_depth) - 1'b1);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= CNT_W'(DEPTH));
    p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> ack_id < 10'd1021);
    p_below_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cand_prio < mask_q);
    p_quiet_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_stb && !eoi_stb) |=> $stable(stk_depth));
endmodule

bind cpu_int_iface cpu_int_iface_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ack_stb(ack_stb), .ack_id(ack_id),
    .eoi_stb(eoi_stb), .cand_prio(cand_prio), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ctrl_en(ctrl_en),
    .mask_q(mask_q), .stk_depth(stk_depth)
);

// File: tb/cpu_int_iface_bench.sv
`timescale 1ns/1ps
module cpu_int_iface_bench;
    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, ack_stb, eoi_stb;
    logic [9:0]  ack_id, eoi_id;

    int errors = 0, checks = 0;
    int m_ctrl = 0, m_mask = 0;
    int q_id[$], q_pr[$];
    bit finished = 0;

    always #10 clk = ~clk;

    cpu_int_iface #(.DEPTH(DEPTH)) u_cpu_int_iface (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_prio(cand_prio), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .ack_stb(ack_stb), .ack_id(ack_id),
        .eoi_stb(eoi_stb), .eoi_id(eoi_id)
    );

    function automatic bit m_qual();
        int p = int'(cand_prio);
        if (m_ctrl == 0 || !cand_valid) return 0;
        if (int'(cand_id) >= 1021) return 0;
        if (p >= m_mask) return 0;
        if (q_id.size() >= DEPTH) return 0;
        if (q_pr.size() > 0 && p >= q_pr[$]) return 0;
        return 1;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare at the falling edge, advance the model, then release the bus.
    task automatic step(string tag);
        bit q, rd, wr, e_ack, e_eoi;
        longint e_rd;
        @(negedge clk);
        q  = m_qual();
        rd = bus_sel && !bus_wr;
        wr = bus_sel && bus_wr;
        e_ack = rd && bus_addr == 2 && q;
        e_eoi = wr && bus_addr == 3 && q_id.size() > 0 && int'(bus_wdata[9:0]) == q_id[$];
        chk(tag, "irq_o", irq_o, q);
        chk(tag, "ack_stb", ack_stb, e_ack);
        chk(tag, "eoi_stb", eoi_stb, e_eoi);
        if (e_ack) chk(tag, "ack_id", ack_id, cand_id);
        if (e_eoi) chk(tag, "eoi_id", eoi_id, q_id[$]);
        if (rd) begin
            case (bus_addr)
                4'd0: e_rd = m_ctrl;
                4'd1: e_rd = m_mask;
                4'd2: e_rd = q ? cand_id : 1023;
                default: e_rd = 0;
            endcase
            chk(tag, "rdata", bus_rdata, e_rd);
        end
        if (rst_n) begin
            if (wr && bus_addr == 0) m_ctrl = int'(bus_wdata[0]);
            if (wr && bus_addr == 1) m_mask = int'(bus_wdata[7:0]);
            if (e_ack) begin q_id.push_back(int'(cand_id)); q_pr.push_back(int'(cand_prio)); end
            if (e_eoi) begin void'(q_id.pop_back()); void'(q_pr.pop_back()); end
        end
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = 4'(a); step(tag);
    endtask

    task automatic wr(int a, int d, string tag);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = 32'(d); step(tag);
    endtask

    task automatic cand(int id, int pr);
        cand_valid = 1; cand_id = 10'(id); cand_prio = 8'(pr);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) step("R1");
        @(negedge clk); rst_n = 1'b1; @(posedge clk); #1;
        cand(40, 8'hA0);
        rd(2, "R1"); rd(0, "R1"); rd(1, "R1");
        // R11 readback and unmapped words
        wr(0, 32'hFFFF_FFFF, "R11"); wr(1, 32'h1234_56F0, "R11");
        rd(0, "R11"); rd(1, "R11"); wr(7, 0, "R11"); rd(7, "R11"); rd(0, "R11");
        // R4 threshold boundary
        step("R4");
        cand(40, 8'hF0); step("R4");
        cand(40, 8'hEF); step("R4");
        // R5 enable gating
        wr(0, 0, "R5"); step("R5"); rd(2, "R5");
        wr(0, 1, "R5");
        // R2 claim, R7 running priority
        cand(40, 8'hA0); rd(2, "R2");
        step("R7"); cand(41, 8'hA0); step("R7");
        cand(77, 8'h9F); step("R7"); rd(2, "R2");
        // R9 full stack, R3 spurious
        cand(5, 8'h10); step("R9"); rd(2, "R3"); rd(2, "R3");
        // R8 mismatching then matching completions
        wr(3, 40, "R8"); step("R8"); wr(3, 77, "R8"); step("R8");
        wr(3, 40, "R8"); wr(3, 40, "R8"); step("R8");
        // R6 reserved numbers
        cand(1021, 0); step("R6"); rd(2, "R6");
        cand(1022, 0); step("R6"); cand(1023, 0); rd(2, "R6");
        cand(500, 8'h30); cand_valid = 0; step("R10"); rd(2, "R10");
        // R2 candidate changes in the claim cycle
        cand(300, 8'h50); step("R2"); cand(301, 8'h20); rd(2, "R2"); step("R7");
        wr(3, 301, "R8"); step("R10");
        // R10 random mix
        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom_range(0, 9));
            int pick = int'($urandom_range(0, 4));
            int ids[5] = '{5, 40, 300, 1021, 1023};
            cand(ids[pick], int'($urandom_range(0, 255)));
            cand_valid = ($urandom_range(0, 7) != 0);
            if (op < 4) rd(2, "R10");
            else if (op < 6) wr(3, (q_id.size() > 0 && op == 4) ? q_id[$] : ids[pick], "R10");
            else if (op == 6) wr(1, int'($urandom_range(0, 255)), "R10");
            else if (op == 7) wr(0, ($urandom_range(0, 5) != 0) ? 1 : 0, "R10");
            else step("R10");
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule